// File: doc/BRIEF.md
# Gray-Coded Control Bus Crossing

This block moves a multi-bit control bus from a source clock domain into an unrelated destination clock domain. The source value is registered once on the source clock. Each bit then passes through its own chain of synchronizer flops on the destination clock. The bits are not sampled together, so in one destination cycle some bits can hold the new value while others still hold the old one. The crossing stays coherent only when every update of the bus flips at most one bit, as a Gray-coded counter or state does.

A monitor in the source domain compares each value the launch register takes with the value it held before. It raises a sticky error flag when the two differ in more than one bit position. A repeated value is legal. The flag stays set until the source reset. The destination bus and the synchronizer chains clear on the destination reset.

Top module: `gray_bus_xing`

## Requirements
- R1: While the destination reset is asserted, `dst_bus` reads all zeros. While the source reset is asserted, `src_err` reads 0.
- R2: When a source value is held for at least one source cycle plus SYNC_STAGES+1 destination cycles, `dst_bus` equals that value (latency: one source register plus SYNC_STAGES destination flops per bit).
- R3: An update of the launch register that flips exactly one bit leaves a clear `src_err` clear.
- R4: A source value that repeats (distance 0) leaves a clear `src_err` clear.
- R5: An update that flips two or more bits sets `src_err`. The flag is visible after the same source edge that loads the offending value; the distance is measured against the previous launch value, which is zero after reset.
- R6: Once set, `src_err` stays 1 under any further input until the source reset is asserted.
- R7: When a Gray sequence is driven and each code is held long enough for R2, every destination sample equals either the previous code or the current code. It never shows a mixed combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_bus | input | WIDTH | Control bus in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_bus | output | WIDTH | Synchronized control bus in the destination domain |
| src_err | output | 1 | Sticky flag: some update flipped more than one bit |

## Verification
The hardest situation to reach from the ports is a multi-bit flip that follows an arbitrary earlier history, including the first value after reset, which is measured against zero. The bench reaches it by sweeping every ordered pair of 4-bit values. Each pair starts from a fresh source reset, and the bench compares the flag with a popcount computed in the bench. Coherence at the destination is observed with source and destination clocks of unrelated periods (10 and 7 time units), so edges drift through every relative phase. Every destination sample is checked against the two codes that can legally be present.

// File: rtl/gray_bus_xing.sv
module gray_bus_xing #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [WIDTH-1:0] src_bus,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_bus,
  output logic             src_err
);

  localparam int DEPTH = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] src_q;
  logic [WIDTH-1:0] flips;
  logic             multi_flip;

  assign flips      = src_bus ^ src_q;
  assign multi_flip = |(flips & (flips - ONE));

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      src_q   <= '0;
      src_err <= 1'b0;
    end else begin
      src_q   <= src_bus;
      src_err <= src_err | multi_flip;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) chain <= '0;
      else            chain <= {chain[DEPTH-2:0], src_q[b]};
    end
    assign dst_bus[b] = chain[DEPTH-1];
  end

  p_multi_sets_err_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    ($countones(src_bus ^ src_q) > 1) |=> src_err);

  p_err_sticky_r6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_err |=> src_err);

  p_single_keeps_clear_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (!src_err && ($countones(src_bus ^ src_q) <= 1)) |=> !src_err);

  p_dst_reset_r1: assert property (@(posedge dst_clk)
    !dst_rst_n |=> (dst_bus == '0));

endmodule

// File: tb/tb_gray_bus_xing.sv
module tb_gray_bus_xing;
  localparam int CLK_PERIOD = 10;
  localparam int DST_PERIOD = 7;
  localparam int W = 4;

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic [W-1:0] src_bus = '0;
  logic [W-1:0] dst_bus;
  logic src_err;

  int checks = 0, errors = 0;
  logic mon_en = 0;
  logic [W-1:0] prev_code = '0, cur_code = '0;

  always #(CLK_PERIOD/2) src_clk = ~src_clk;
  always #(DST_PERIOD/2.0) dst_clk = ~dst_clk;

  gray_bus_xing #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_bus(src_bus),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_bus(dst_bus), .src_err(src_err));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return n;
  endfunction

  task automatic src_cycles(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  // R7: every destination sample is one of the two codes in flight
  always @(negedge dst_clk) begin
    if (mon_en) begin
      checks++;
      if (dst_bus !== prev_code && dst_bus !== cur_code) begin
        errors++;
        $display("FAIL R7: actual %0h expected %0h or %0h", dst_bus, prev_code, cur_code);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    src_cycles(3);
    chk("R1 dst reset", dst_bus, '0);
    chk("R1 src reset", {{(W-1){1'b0}}, src_err}, '0);
    src_rst_n = 1; dst_rst_n = 1;
    src_cycles(2);

    // Gray sweep: R2 latency, R3/R4 no error, R7 coherence
    mon_en = 1;
    for (int i = 1; i < 16; i++) begin
      logic [W-1:0] g;
      g = W'(i ^ (i >> 1));
      prev_code = cur_code;
      cur_code  = g;
      src_bus   = g;
      src_cycles(4);
      chk("R2 dst value", dst_bus, g);
      chk("R3 gray step", {{(W-1){1'b0}}, src_err}, '0);
    end
    mon_en = 0;
    chk("R4 held value", {{(W-1){1'b0}}, src_err}, '0);

    // Binary counter: 1000 -> 0000 -> 0001 -> 0010 (two bits flip)
    src_bus = 4'b0000; src_cycles(1);
    src_bus = 4'b0001; src_cycles(1);
    chk("R3 binary single step", {{(W-1){1'b0}}, src_err}, '0);
    src_bus = 4'b0010; src_cycles(1);
    chk("R5 binary double step", {{(W-1){1'b0}}, src_err}, 4'b0001);
    src_bus = 4'b0011; src_cycles(1);
    src_bus = 4'b0011; src_cycles(2);
    chk("R6 sticky", {{(W-1){1'b0}}, src_err}, 4'b0001);
    src_rst_n = 0; src_cycles(1);
    chk("R1 src reset clears", {{(W-1){1'b0}}, src_err}, '0);
    src_rst_n = 1; src_cycles(1);

    // Exhaustive pairs from reset: 0 -> a -> b
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic exp1, exp2;
        src_rst_n = 0; src_bus = '0; src_cycles(1);
        src_rst_n = 1;
        src_bus = W'(a); src_cycles(1);
        exp1 = pc(W'(a)) > 1;
        chk("R5 first from reset", {{(W-1){1'b0}}, src_err}, {{(W-1){1'b0}}, exp1});
        src_bus = W'(b); src_cycles(1);
        exp2 = exp1 || (pc(W'(a ^ b)) > 1);
        chk("R5 pair", {{(W-1){1'b0}}, src_err}, {{(W-1){1'b0}}, exp2});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule